// File: doc/BRIEF.md
# Registered RAM Read Port with Gated Reset

This block is a single-port synchronous RAM whose read path runs through two stages. The first stage, the output latch, captures the addressed word on every enabled clock edge. The second stage is an optional output register that samples the latch. Both stages can be forced to a constant reset value by a synchronous, active-high reset.

That reset does not act on its own. An enable gates it, and a parameter picks which enable gates which stage. In split gating, the port enable gates the latch reset and the register clock enable gates the register reset. In port gating, the port enable alone gates the reset of both stages, and the register clock enable plays no part in reset.

The reset touches only the read stages. The storage array is written whenever the port enable and the write enable are both high, whatever the reset does.

Top module: `ram_rd_rst`

## Requirements
- R1: A read at address A presents the word stored at A on `dout` after two rising edges when the output register is present, with `regce` high on the second edge. Without the register it appears after one edge. A write and a read of the same address in one cycle return the old word (read-first).
- R2: In split gating, a reset loads the latch with `RST_VAL` only on an edge where `en` is high. With `en` low, the latch keeps its contents.
- R3: In split gating, a reset loads the output register with `RST_VAL` only on an edge where `regce` is high. This holds whatever the value of `en`.
- R4: In port gating (`GATE` = 1), `rst` with `en` high loads `RST_VAL` into both the latch and the register. The value of `regce` makes no difference to this.
- R5: In port gating, `rst` with `en` low does not force `RST_VAL` anywhere. The latch holds, and the register captures the latch when `regce` is high.
- R6: With the output register present, suppose one reset cycle has `en` and `regce` both high and the next edge has `regce` high. Then `dout` shows `RST_VAL` for two consecutive cycles.
- R7: After power-up and before any enabled operation, `dout` is all zeros. This is independent of the `RST_VAL` parameter.
- R8: On an edge with `en` low, the latch is unchanged and no write takes place.
- R9: A gated reset takes priority over a read on the same edge. Reset never changes the array, and a write issued during a reset cycle is stored.
- R10: When `regce` is low and no gated reset applies to the register, the register holds its value.
- R11: The gating mode is a parameter: value 0 selects split gating and value 1 selects port gating. `OUT_REG` = 0 removes the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| en | input | 1 | Port enable: read, write and gated latch reset |
| regce | input | 1 | Clock enable of the output register |
| rst | input | 1 | Synchronous active-high reset of the read stages |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| we | input | 1 | Write enable, qualified by `en` |
| dout | output | DW | Read data |

## Verification
The hardest situations to reach are reset cycles where the two enables disagree. Those are the only cycles where split gating and port gating produce different outputs, and each lasts a single edge before the next read overwrites the evidence. The bench drives one input stream into three instances at the same time: split gating, port gating, and split gating without the register. It follows each reset with `en` low, `regce` low, or both, so that on the same cycle the instances diverge in a way a model can predict. It then reads the stages out through the normal read path.

// File: rtl/rdrst_pkg.sv
package rdrst_pkg;

    typedef enum logic {
        GATE_SPLIT = 1'b0,
        GATE_PORT  = 1'b1
    } gate_mode_e;

    // Per-stage control: clear forces the reset value, load captures data.
    typedef struct packed {
        logic clear;
        logic load;
    } stage_ctl_t;

    // Request presented to the read port on one cycle.
    typedef struct packed {
        logic en;
        logic regce;
        logic rst;
        logic we;
    } port_req_t;

    function automatic stage_ctl_t latch_ctl(input port_req_t r);
        stage_ctl_t c;
        c.clear = r.en & r.rst;
        c.load  = r.en;
        return c;
    endfunction

    function automatic stage_ctl_t oreg_ctl(input gate_mode_e m, input port_req_t r);
        stage_ctl_t c;
        if (m == GATE_SPLIT) begin
            c.clear = r.rst & r.regce;
        end else begin
            c.clear = r.rst & r.en;
        end
        c.load = c.clear | r.regce;
        return c;
    endfunction

endpackage

// File: rtl/ram_rd_array.sv
module ram_rd_array #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH] = '{default: '0};

    // Read-first: the read sees the word from before this edge's write.
    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (wr) begin
            mem[addr] <= wdata;
        end
    end
endmodule

// File: rtl/ram_rd_stage.sv
module ram_rd_stage
    import rdrst_pkg::*;
#(
    parameter int            DW      = 16,
    parameter logic [DW-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  stage_ctl_t    ctl,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);
    logic [DW-1:0] q_r = '0;

    always_ff @(posedge clk) begin
        if (ctl.clear) begin
            q_r <= RST_VAL;
        end else if (ctl.load) begin
            q_r <= d;
        end
    end

    assign q = q_r;
endmodule

// File: rtl/ram_rd_rst.sv
module ram_rd_rst
    import rdrst_pkg::*;
#(
    parameter int            DW      = 16,
    parameter int            AW      = 4,
    parameter logic [DW-1:0] RST_VAL = 16'hA5C3,
    parameter bit            OUT_REG = 1'b1,
    parameter gate_mode_e    GATE    = GATE_SPLIT
) (
    input  logic          clk,
    input  logic          en,
    input  logic          regce,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          we,
    output logic [DW-1:0] dout
);
    port_req_t     req;
    stage_ctl_t    lat_ctl;
    logic [DW-1:0] rdata;
    logic [DW-1:0] lat_q;
    logic [DW-1:0] reg_q;

    always_comb begin
        req.en    = en;
        req.regce = regce;
        req.rst   = rst;
        req.we    = we;
        lat_ctl   = latch_ctl(req);
    end

    ram_rd_array #(.DW(DW), .AW(AW)) u_array (
        .clk   (clk),
        .wr    (req.en & req.we),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    ram_rd_stage #(.DW(DW), .RST_VAL(RST_VAL)) u_latch (
        .clk (clk),
        .ctl (lat_ctl),
        .d   (rdata),
        .q   (lat_q)
    );

    generate
        if (OUT_REG) begin : g_oreg
            stage_ctl_t reg_ctl;
            always_comb reg_ctl = oreg_ctl(GATE, req);
            ram_rd_stage #(.DW(DW), .RST_VAL(RST_VAL)) u_oreg (
                .clk (clk),
                .ctl (reg_ctl),
                .d   (lat_q),
                .q   (reg_q)
            );
        end else begin : g_noreg
            assign reg_q = lat_q;
        end
    endgenerate

    assign dout = reg_q;
endmodule

// File: rtl/ram_rd_rst_chk.sv
module ram_rd_rst_chk
    import rdrst_pkg::*;
#(
    parameter int            DW      = 16,
    parameter logic [DW-1:0] RST_VAL = 16'hA5C3,
    parameter bit            OUT_REG = 1'b1,
    parameter gate_mode_e    GATE    = GATE_SPLIT
) (
    input logic          clk,
    input logic          en,
    input logic          regce,
    input logic          rst,
    input logic [DW-1:0] lat_q,
    input logic [DW-1:0] reg_q,
    input logic [DW-1:0] dout
);
    // rst is functional here, so checks are held off only until the first edge.
    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    p_latch_clear_r2: assert property (@(posedge clk) disable iff (!armed)
        en && rst |=> lat_q == RST_VAL);

    p_latch_hold_r8: assert property (@(posedge clk) disable iff (!armed)
        !en |=> $stable(lat_q));

    generate
        if (OUT_REG) begin : g_reg
            if (GATE == GATE_SPLIT) begin : g_split
                p_reg_rst_r3: assert property (@(posedge clk) disable iff (!armed)
                    rst && regce |=> reg_q == RST_VAL);
                p_reg_hold_r10: assert property (@(posedge clk) disable iff (!armed)
                    !regce |=> $stable(reg_q));
            end else begin : g_port
                p_reg_rst_r4: assert property (@(posedge clk) disable iff (!armed)
                    rst && en |=> reg_q == RST_VAL);
                p_no_force_r5: assert property (@(posedge clk) disable iff (!armed)
                    rst && !en && regce |=> reg_q == $past(lat_q));
                p_reg_hold_r10: assert property (@(posedge clk) disable iff (!armed)
                    !regce && !(rst && en) |=> $stable(reg_q));
            end
            p_two_cycle_r6: assert property (@(posedge clk) disable iff (!armed)
                regce && $past(rst && en && regce) |=> dout == RST_VAL);
        end
    endgenerate
endmodule

bind ram_rd_rst ram_rd_rst_chk #(
    .DW(DW), .RST_VAL(RST_VAL), .OUT_REG(OUT_REG), .GATE(GATE)
) u_chk (
    .clk(clk), .en(en), .regce(regce), .rst(rst),
    .lat_q(lat_q), .reg_q(reg_q), .dout(dout)
);

// File: tb/sim_ram_rd_rst.sv
module sim_ram_rd_rst;
    import rdrst_pkg::*;

    localparam int            CLK_P = 10;
    localparam int            DW    = 16;
    localparam int            AW    = 4;
    localparam logic [DW-1:0] RV    = 16'hA5C3;

    logic          clk = 1'b0;
    logic          en = 1'b0, regce = 1'b0, rst = 1'b0, we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] dout0, dout1, dout2;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    // u0: split gating with register, u1: port gating with register, u2: no register
    ram_rd_rst #(.DW(DW), .AW(AW), .RST_VAL(RV), .OUT_REG(1'b1), .GATE(GATE_SPLIT)) u0 (
        .clk(clk), .en(en), .regce(regce), .rst(rst), .addr(addr),
        .wdata(wdata), .we(we), .dout(dout0));
    ram_rd_rst #(.DW(DW), .AW(AW), .RST_VAL(RV), .OUT_REG(1'b1), .GATE(GATE_PORT)) u1 (
        .clk(clk), .en(en), .regce(regce), .rst(rst), .addr(addr),
        .wdata(wdata), .we(we), .dout(dout1));
    ram_rd_rst #(.DW(DW), .AW(AW), .RST_VAL(RV), .OUT_REG(1'b0), .GATE(GATE_SPLIT)) u2 (
        .clk(clk), .en(en), .regce(regce), .rst(rst), .addr(addr),
        .wdata(wdata), .we(we), .dout(dout2));

    // Reference model built from the requirements
    logic [DW-1:0] mem_m [1 << AW];
    logic [DW-1:0] lat_m = '0, regs_m = '0, regp_m = '0;

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(16'h1100 + a * 16'h0203);
    endfunction

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic e, input logic rce, input logic r, input logic w,
                        input int a, input logic [DW-1:0] d, input string tag);
        logic [DW-1:0] nl, ns, np;
        en = e; regce = rce; rst = r; we = w; addr = AW'(a); wdata = d;
        @(posedge clk);
        nl = e ? (r ? RV : mem_m[a]) : lat_m;
        ns = (r && rce) ? RV : (rce ? lat_m : regs_m);
        np = (r && e) ? RV : (rce ? lat_m : regp_m);
        if (e && w) mem_m[a] = d;
        lat_m = nl; regs_m = ns; regp_m = np;
        @(negedge clk);
        chk(dout0, regs_m, {tag, " split"});
        chk(dout1, regp_m, {tag, " port"});
        chk(dout2, lat_m,  {tag, " noreg"});
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 1'b0, 1'b0, 0, '0, tag);
    endtask

    task automatic t_powerup();   // R7
        for (int i = 0; i < 3; i++) idle("R7 idle");
        chk(dout0, '0, "R7 power-up zero");
        chk(dout2, '0, "R7 power-up zero noreg");
    endtask

    task automatic t_fill();      // R8, R1 read-first
        step(1'b0, 1'b1, 1'b0, 1'b1, 5, 16'hDEAD, "R8 write with en low");
        for (int i = 0; i < (1 << AW); i++)
            step(1'b1, 1'b1, 1'b0, 1'b1, i, pat(i), "R1 fill read-first");
        step(1'b1, 1'b1, 1'b0, 1'b0, 5, '0, "R8 read after blocked write");
        chk(dout2, pat(5), "R8 blocked write absent");
    endtask

    task automatic t_read();      // R1
        step(1'b1, 1'b1, 1'b0, 1'b0, 3, '0, "R1 read");
        chk(dout2, pat(3), "R1 one-edge latency");
        step(1'b1, 1'b1, 1'b0, 1'b0, 9, '0, "R1 read");
        chk(dout0, pat(3), "R1 two-edge latency");
        step(1'b1, 1'b1, 1'b0, 1'b1, 9, 16'h7777, "R1 read-first");
        chk(dout2, pat(9), "R1 read-first old word");
        step(1'b1, 1'b1, 1'b0, 1'b0, 9, '0, "R1 read new");
        chk(dout2, 16'h7777, "R1 new word");
        for (int i = 15; i >= 0; i -= 3) step(1'b1, 1'b1, 1'b0, 1'b0, i, '0, "R1 sweep");
    endtask

    task automatic t_split();     // R2, R3, R5
        step(1'b1, 1'b1, 1'b0, 1'b0, 2, '0, "R2 prime");
        step(1'b0, 1'b1, 1'b1, 1'b0, 0, '0, "R2 rst en low");
        chk(dout2, pat(2), "R2 latch untouched");
        chk(dout0, RV, "R3 reg reset by regce");
        chk(dout1, pat(2), "R5 port mode no force");
        step(1'b1, 1'b0, 1'b1, 1'b0, 4, '0, "R3 rst regce low");
        chk(dout2, RV, "R2 latch reset with en");
        chk(dout0, RV, "R3 reg holds");
        step(1'b1, 1'b1, 1'b0, 1'b0, 6, '0, "R3 recover");
        step(1'b1, 1'b1, 1'b0, 1'b0, 6, '0, "R3 recover");
        step(1'b1, 1'b0, 1'b1, 1'b0, 7, '0, "R4 rst regce low");
        chk(dout1, RV, "R4 port mode ignores regce");
        chk(dout0, pat(6), "R3 split holds without regce");
    endtask

    task automatic t_two();       // R6
        step(1'b1, 1'b1, 1'b0, 1'b0, 1, '0, "R6 prime");
        step(1'b1, 1'b1, 1'b1, 1'b0, 1, '0, "R6 reset");
        chk(dout0, RV, "R6 first cycle");
        step(1'b1, 1'b1, 1'b0, 1'b0, 8, '0, "R6 read");
        chk(dout0, RV, "R6 second cycle");
        chk(dout1, RV, "R6 second cycle port");
        step(1'b1, 1'b1, 1'b0, 1'b0, 8, '0, "R6 read");
        chk(dout0, pat(8), "R6 data returns");
    endtask

    task automatic t_prio();      // R9
        step(1'b1, 1'b1, 1'b1, 1'b1, 10, 16'h4242, "R9 rst with write");
        chk(dout2, RV, "R9 reset beats read");
        step(1'b1, 1'b1, 1'b0, 1'b0, 10, '0, "R9 read back");
        chk(dout2, 16'h4242, "R9 write stored");
        step(1'b1, 1'b1, 1'b1, 1'b0, 11, '0, "R9 rst");
        step(1'b1, 1'b1, 1'b0, 1'b0, 11, '0, "R9 array intact");
        chk(dout2, pat(11), "R9 array intact");
    endtask

    task automatic t_hold();      // R10
        step(1'b1, 1'b1, 1'b0, 1'b0, 12, '0, "R10 prime");
        step(1'b1, 1'b1, 1'b0, 1'b0, 13, '0, "R10 prime");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b0, i, '0, "R10 hold");
        chk(dout0, pat(12), "R10 split holds");
        chk(dout1, pat(12), "R10 port holds");
        step(1'b0, 1'b0, 1'b1, 1'b0, 0, '0, "R10 port rst en low regce low");
        chk(dout1, pat(12), "R5 R10 port no change");
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem_m[i] = '0;
        @(negedge clk);
        t_powerup();
        t_fill();
        t_read();
        t_split();
        t_two();
        t_prio();
        t_hold();
        idle("R11 end");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule